// File: doc/BRIEF.md
# Framed Stream Readout Buffer

This block sits between a framed 32-bit data source and a synchronous register bus. The source delivers up to two words per clock (a low lane and an optional high lane) while its data-enable is high. A one-clock framing pulse marks the start of a frame, and a second pulse marks its end. Incoming words go into an on-chip buffer. A host reads the buffer through a memory window at the bottom of the register space. Three counters and a two-bit flag register describe what the buffer holds.

Frames can be longer than the buffer. When the buffer reaches a fill threshold it sets a stop flag and raises throttle. The threshold leaves enough headroom to absorb the words the source may still send during its reaction latency. The host drains the stored part, then writes the flag register. That write empties the buffer, clears the flags and releases throttle, so the next part of the same frame can flow. A separate flag reports that the stored data closes the current frame.

Top module: `fvb_stream_buf`

## Requirements
- R1: After reset, the amount, event-number and event-length registers read 0, the flag register reads 0 and throttle is low.
- R2: A word is stored only in a cycle with `s_en` high. `s_lo` is stored first, then `s_hi` when `s_hi_ok` is high. Stored word i reads back at byte address 4*i (starting at 0) in arrival order.
- R3: The register at 0x820 returns the number of 32-bit words currently held in the buffer.
- R4: A framing pulse while no frame is open starts a frame and increments the event number at 0x824, so the first frame is number 1. The next pulse closes the frame.
- R5: The event length at 0x828 restarts from zero at each frame start. It counts every stored word of the frame across all buffer parts.
- R6: Bit 0 of 0x82C (stop flag) becomes 1 at the clock edge where the stored amount reaches DEPTH-HEADROOM (50 by default). Throttle is high from the following cycle.
- R7: Bit 1 of 0x82C (final-part flag) becomes 1 at the clock edge of a frame-closing pulse. Throttle stays high while either flag is 1.
- R8: Any bus write to 0x82C clears both flags, empties the buffer (amount 0, next word stored at address 0) and releases throttle. The event number and event length are unchanged.
- R9: When the clearing write and an incoming beat fall in the same cycle, the beat's words are stored from address 0, and the amount equals that beat's word count.
- R10: Words arriving while the buffer already holds DEPTH words are discarded and counted nowhere. The amount never exceeds DEPTH.
- R11: Bus writes to any address other than 0x82C have no effect. Reads of unmapped addresses return 0. Read data appears one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_en | input | 1 | Stream data-enable |
| s_hi_ok | input | 1 | High lane word valid in this beat |
| s_frame | input | 1 | One-clock framing pulse (start, then end) |
| s_lo | input | 32 | First word of the beat |
| s_hi | input | 32 | Second word of the beat |
| throttle | output | 1 | Asks the source to stop sending |
| bus_addr | input | 12 | Register bus byte address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_rdata | output | 32 | Register bus read data, one cycle after the address |

## Verification
The host's clearing write and a fresh two-word beat from the source can land in the same clock. The bench provokes this by driving a beat and the flag-register write together, right after the host has drained a stop-flagged part of a long frame. The result is judged from what follows: the amount must read 2, both flags must read 0 and throttle must drop. The first two words read back at addresses 0 and 4 must be that beat's words, before the words that follow it.

// File: rtl/fvb_pkg.sv
package fvb_pkg;

    localparam int BUS_AW = 12;

    localparam logic [BUS_AW-1:0] OFS_AMOUNT = 12'h820;
    localparam logic [BUS_AW-1:0] OFS_EVNUM  = 12'h824;
    localparam logic [BUS_AW-1:0] OFS_EVLEN  = 12'h828;
    localparam logic [BUS_AW-1:0] OFS_FLAGS  = 12'h82C;

    // One clock of the incoming stream: two lanes, low lane first.
    typedef struct packed {
        logic        en;
        logic        hi_ok;
        logic [31:0] hi;
        logic [31:0] lo;
    } beat_t;

    // Handshake flags; bit 0 stop, bit 1 final part.
    typedef struct packed {
        logic last;
        logic run_stop;
    } flags_t;

    function automatic logic [31:0] flags_word(flags_t f);
        return {30'd0, f.last, f.run_stop};
    endfunction

endpackage

// File: rtl/fvb_ram.sv
module fvb_ram #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we0,
    input  logic [AW-1:0] wa0,
    input  logic [31:0]   wd0,
    input  logic          we1,
    input  logic [AW-1:0] wa1,
    input  logic [31:0]   wd1,
    input  logic [AW-1:0] ra,
    output logic [31:0]   rd
);

    logic [31:0] mem [DEPTH];

    // Two write lanes always target distinct, consecutive addresses.
    always_ff @(posedge clk) begin
        if (we0) mem[wa0] <= wd0;
        if (we1) mem[wa1] <= wd1;
    end

    assign rd = mem[ra];

endmodule

// File: rtl/fvb_fill.sv
module fvb_fill
    import fvb_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int HEADROOM = 14,
    parameter int AW       = $clog2(DEPTH),
    parameter int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  beat_t         beat,
    input  logic          end_pulse,
    output logic          we0,
    output logic          we1,
    output logic [AW-1:0] wa0,
    output logic [AW-1:0] wa1,
    output logic [1:0]    stored,
    output logic [CW-1:0] amount,
    output flags_t        flags,
    output logic          throttle
);

    localparam logic [CW:0]   CAP = (CW+1)'(DEPTH);
    localparam logic [CW-1:0] THR = CW'(DEPTH - HEADROOM);

    logic [CW-1:0] amount_q;
    logic [CW-1:0] base;
    logic [CW-1:0] new_amt;
    logic          ok0;
    logic          ok1;
    flags_t        flags_q;

    // A clear in the same cycle restarts the write address at zero.
    always_comb begin
        base    = clear ? '0 : amount_q;
        ok0     = beat.en && ({1'b0, base} < CAP);
        ok1     = ok0 && beat.hi_ok && (({1'b0, base} + 1'b1) < CAP);
        new_amt = base + CW'(ok0) + CW'(ok1);
    end

    assign we0    = ok0;
    assign we1    = ok1;
    assign wa0    = base[AW-1:0];
    assign wa1    = base[AW-1:0] + 1'b1;
    assign stored = 2'(ok0) + 2'(ok1);

    always_ff @(posedge clk) begin
        if (rst) begin
            amount_q <= '0;
            flags_q  <= '0;
        end else begin
            amount_q         <= new_amt;
            flags_q.run_stop <= (new_amt >= THR) | (flags_q.run_stop & ~clear);
            flags_q.last     <= end_pulse | (flags_q.last & ~clear);
        end
    end

    assign amount   = amount_q;
    assign flags    = flags_q;
    assign throttle = flags_q.run_stop | flags_q.last;

endmodule

// File: rtl/fvb_frame.sv
module fvb_frame (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame,
    input  logic [1:0]  stored,
    output logic        end_pulse,
    output logic        in_frame,
    output logic [31:0] evnum,
    output logic [31:0] evlen
);

    logic        in_frame_q;
    logic        start;
    logic [31:0] evnum_q;
    logic [31:0] evlen_q;

    assign start     = frame & ~in_frame_q;
    assign end_pulse = frame & in_frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            evnum_q    <= '0;
            evlen_q    <= '0;
        end else begin
            in_frame_q <= in_frame_q ^ frame;
            evnum_q    <= evnum_q + 32'(start);
            evlen_q    <= (start ? 32'd0 : evlen_q) + 32'(stored);
        end
    end

    assign in_frame = in_frame_q;
    assign evnum    = evnum_q;
    assign evlen    = evlen_q;

endmodule

// File: rtl/fvb_stream_buf.sv
module fvb_stream_buf
    import fvb_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int HEADROOM = 14
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        s_en,
    input  logic        s_hi_ok,
    input  logic        s_frame,
    input  logic [31:0] s_lo,
    input  logic [31:0] s_hi,
    output logic        throttle,
    input  logic [11:0] bus_addr,
    input  logic        bus_wr,
    output logic [31:0] bus_rdata
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [BUS_AW-1:0] RAM_TOP = BUS_AW'(DEPTH * 4);

    beat_t         beat;
    logic          clear;
    logic          end_pulse;
    logic          in_frame;
    logic [31:0]   evnum;
    logic [31:0]   evlen;
    logic          we0;
    logic          we1;
    logic [AW-1:0] wa0;
    logic [AW-1:0] wa1;
    logic [1:0]    stored;
    logic [CW-1:0] amount;
    flags_t        flags;
    logic [AW-1:0] ram_ra;
    logic [31:0]   ram_rd;
    logic [31:0]   rdata_q;

    always_comb begin
        beat.en    = s_en;
        beat.hi_ok = s_hi_ok;
        beat.hi    = s_hi;
        beat.lo    = s_lo;
    end

    assign clear  = bus_wr && (bus_addr == OFS_FLAGS);
    assign ram_ra = bus_addr[AW+1:2];

    fvb_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .frame     (s_frame),
        .stored    (stored),
        .end_pulse (end_pulse),
        .in_frame  (in_frame),
        .evnum     (evnum),
        .evlen     (evlen)
    );

    fvb_fill #(.DEPTH(DEPTH), .HEADROOM(HEADROOM), .AW(AW), .CW(CW)) u_fill (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .beat      (beat),
        .end_pulse (end_pulse),
        .we0       (we0),
        .we1       (we1),
        .wa0       (wa0),
        .wa1       (wa1),
        .stored    (stored),
        .amount    (amount),
        .flags     (flags),
        .throttle  (throttle)
    );

    fvb_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk (clk),
        .we0 (we0),
        .wa0 (wa0),
        .wd0 (beat.lo),
        .we1 (we1),
        .wa1 (wa1),
        .wd1 (beat.hi),
        .ra  (ram_ra),
        .rd  (ram_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_addr < RAM_TOP) begin
            rdata_q <= ram_rd;
        end else begin
            case (bus_addr)
                OFS_AMOUNT: rdata_q <= 32'(amount);
                OFS_EVNUM:  rdata_q <= evnum;
                OFS_EVLEN:  rdata_q <= evlen;
                OFS_FLAGS:  rdata_q <= flags_word(flags);
                default:    rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/fvb_checker.sv
module fvb_checker
    import fvb_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int HEADROOM = 14,
    parameter int CW       = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          s_en,
    input logic          s_frame,
    input logic          bus_wr,
    input logic [11:0]   bus_addr,
    input logic          throttle,
    input logic [CW-1:0] amount,
    input logic          run_stop,
    input logic          last,
    input logic          in_frame,
    input logic [31:0]   evnum
);

    localparam logic [CW-1:0] THR = CW'(DEPTH - HEADROOM);

    logic clr;
    assign clr = bus_wr && (bus_addr == OFS_FLAGS);

    // R10: the buffer count is bounded by its capacity
    assert_amount_bound_R10: assert property (@(posedge clk) disable iff (rst)
        amount <= CW'(DEPTH));

    // R8: a clearing write with no beat leaves an empty buffer and no stop flag
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && !s_en) |=> (amount == '0) && !run_stop);

    // R4: a start pulse advances the event number by one
    assert_evnum_step_R4: assert property (@(posedge clk) disable iff (rst)
        (s_frame && !in_frame) |=> (evnum == $past(evnum) + 32'd1));

    // R3: without data or clear the amount holds
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!s_en && !clr) |=> $stable(amount));

    // R6: the stop flag holds until cleared
    assert_runstop_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (run_stop && !clr) |=> run_stop);

    // R7: throttle only rises for a full buffer or a final part
    assert_throttle_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(throttle) |-> ((amount >= THR) || last));

endmodule

bind fvb_stream_buf fvb_checker #(.DEPTH(DEPTH), .HEADROOM(HEADROOM)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .s_en     (s_en),
    .s_frame  (s_frame),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .throttle (throttle),
    .amount   (amount),
    .run_stop (flags.run_stop),
    .last     (flags.last),
    .in_frame (in_frame),
    .evnum    (evnum)
);

// File: tb/fvb_stream_buf_tb_top.sv
module fvb_stream_buf_tb_top;

    localparam int DEPTH = 64;
    localparam logic [11:0] A_AMOUNT = 12'h820;
    localparam logic [11:0] A_EVNUM  = 12'h824;
    localparam logic [11:0] A_EVLEN  = 12'h828;
    localparam logic [11:0] A_FLAGS  = 12'h82C;

    logic        clk = 1'b0;
    logic        rst;
    logic        s_en, s_hi_ok, s_frame;
    logic [31:0] s_lo, s_hi;
    logic        throttle;
    logic [11:0] bus_addr;
    logic        bus_wr;
    logic [31:0] bus_rdata;

    logic [31:0] exp_q [$];
    int          exp_fill = 0;
    int          word_id  = 0;
    int          n_checks = 0;
    int          n_fail   = 0;
    logic [31:0] d;

    always #5 clk = ~clk;

    fvb_stream_buf dut_i (
        .clk       (clk),
        .rst       (rst),
        .s_en      (s_en),
        .s_hi_ok   (s_hi_ok),
        .s_frame   (s_frame),
        .s_lo      (s_lo),
        .s_hi      (s_hi),
        .throttle  (throttle),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic zero_inputs();
        s_en = 1'b0; s_hi_ok = 1'b0; s_frame = 1'b0;
        s_lo = '0; s_hi = '0; bus_addr = '0; bus_wr = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] w);
        if (exp_fill < DEPTH) begin
            exp_q.push_back(w);
            exp_fill++;
        end
    endtask

    // Driver: one stream beat, optionally with the clearing write in the same cycle.
    task automatic beat(input logic two, input logic clr = 1'b0);
        @(negedge clk);
        zero_inputs();
        s_en    = 1'b1;
        s_hi_ok = two;
        s_lo    = 32'hA500_0000 + 32'(word_id);
        s_hi    = 32'hA500_0000 + 32'(word_id + 1);
        if (clr) begin
            bus_wr   = 1'b1;
            bus_addr = A_FLAGS;
            exp_fill = 0;
        end
        push_word(s_lo);
        if (two) push_word(s_hi);
        word_id += 2;
    endtask

    task automatic idle();
        @(negedge clk);
        zero_inputs();
    endtask

    task automatic junk();
        @(negedge clk);
        zero_inputs();
        s_hi_ok = 1'b1;
        s_lo    = 32'hDEAD_0001;
        s_hi    = 32'hDEAD_0002;
    endtask

    task automatic pulse();
        @(negedge clk);
        zero_inputs();
        s_frame = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a);
        @(negedge clk);
        zero_inputs();
        bus_wr   = 1'b1;
        bus_addr = a;
        if (a == A_FLAGS) exp_fill = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        zero_inputs();
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    // Monitor: read the stored part back and compare with the scoreboard queue.
    task automatic drain(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            rd(12'(i * 4), d);
            if (exp_q.size() == 0) begin
                check({req, " queue underrun"}, d, 32'hFFFF_FFFF);
            end else begin
                check(req, d, exp_q.pop_front());
            end
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        zero_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 throttle", 32'(throttle), 32'd0);
        rd(A_AMOUNT, d); check("R1 amount", d, 32'd0);
        rd(A_EVNUM, d);  check("R1 evnum", d, 32'd0);
        rd(A_EVLEN, d);  check("R1 evlen", d, 32'd0);
        rd(A_FLAGS, d);  check("R1 flags", d, 32'd0);

        // Event 1: mixed beats with a disabled junk beat, 8 words
        pulse();
        beat(1'b1); beat(1'b0); beat(1'b1);
        junk();
        beat(1'b1); beat(1'b0);
        pulse();
        idle();
        check("R7 throttle after end", 32'(throttle), 32'd1);
        rd(A_EVNUM, d);  check("R4 first event number", d, 32'd1);
        rd(A_EVLEN, d);  check("R5 event length", d, 32'd8);
        rd(A_AMOUNT, d); check("R3 amount", d, 32'd8);
        rd(A_FLAGS, d);  check("R7 last flag", d, 32'd2);
        drain("R2 arrival order", 8);

        wr(A_FLAGS);
        idle();
        check("R8 throttle released", 32'(throttle), 32'd0);
        rd(A_AMOUNT, d); check("R8 amount cleared", d, 32'd0);
        rd(A_FLAGS, d);  check("R8 flags cleared", d, 32'd0);
        rd(A_EVNUM, d);  check("R8 evnum kept", d, 32'd1);
        rd(A_EVLEN, d);  check("R8 evlen kept", d, 32'd8);

        // R11: writes elsewhere and unmapped reads
        wr(A_AMOUNT); wr(A_EVNUM); wr(12'h010);
        rd(A_AMOUNT, d); check("R11 amount untouched", d, 32'd0);
        rd(A_EVNUM, d);  check("R11 evnum untouched", d, 32'd1);
        rd(12'h900, d);  check("R11 unmapped read", d, 32'd0);

        // Event 2: long frame split into parts
        pulse();
        for (int i = 0; i < 24; i++) beat(1'b1);
        idle();
        check("R6 throttle below threshold", 32'(throttle), 32'd0);
        beat(1'b1);
        idle();
        check("R6 throttle at threshold", 32'(throttle), 32'd1);
        for (int i = 0; i < 3; i++) beat(1'b1);
        idle();
        rd(A_FLAGS, d);  check("R6 stop flag", d, 32'd1);
        rd(A_AMOUNT, d); check("R3 amount with headroom", d, 32'd56);
        rd(A_EVLEN, d);  check("R5 first part length", d, 32'd56);
        rd(A_EVNUM, d);  check("R4 second event", d, 32'd2);
        drain("R2 first part", 56);

        // R9: clear and beat in the same cycle
        beat(1'b1, 1'b1);
        idle();
        check("R9 throttle released", 32'(throttle), 32'd0);
        rd(A_AMOUNT, d); check("R9 amount equals beat", d, 32'd2);
        rd(A_FLAGS, d);  check("R9 flags cleared", d, 32'd0);
        beat(1'b1); beat(1'b0);
        pulse();
        idle();
        rd(A_AMOUNT, d); check("R3 second part amount", d, 32'd5);
        rd(A_EVLEN, d);  check("R5 length across parts", d, 32'd61);
        rd(A_FLAGS, d);  check("R7 final part flag", d, 32'd2);
        drain("R9 words from address 0", 5);

        // Event 3: overflow past capacity
        wr(A_FLAGS);
        pulse();
        for (int i = 0; i < 34; i++) beat(1'b1);
        idle();
        rd(A_AMOUNT, d); check("R10 amount capped", d, 32'd64);
        rd(A_EVLEN, d);  check("R10 dropped words uncounted", d, 32'd64);
        rd(A_FLAGS, d);  check("R10 stop flag", d, 32'd1);
        rd(A_EVNUM, d);  check("R4 third event", d, 32'd3);
        drain("R10 stored words", 64);
        check("R10 scoreboard empty", 32'(exp_q.size()), 32'd0);

        summary();
    end

endmodule